// File: doc/BRIEF.md
# Quadrature Correlator with Shared Sine/Cosine Reference Table

This block measures how strongly a group of one-bit sigma-delta converter streams correlates with a sine and cosine reference. The same reference also drives a pair of DAC bytes, so a single block can generate a stimulus and measure the response. On every clock, up to four converter bits are combined into one signed sample. Each input has its own enable and its own inversion control.

A phase accumulator steps through a lookup RAM. The RAM provides signed sine and cosine reference bytes for the correlation and two further bytes for the DAC outputs. The sample is multiplied by both reference values. The products feed a two-stage integrator in each of two channels, and the first stage runs either as a loader (Sinc1) or as an accumulator (Sinc2).

Software reads the second-stage sums with a strobe. The read also clears the second stage. Turning the sums into magnitude or power is left to whatever reads them.

Top module: `quad_correlator`

## Requirements
- R1: The sample is the number of enabled inputs whose adjusted bit is 1 minus the number of enabled inputs whose adjusted bit is 0. The adjusted bit is the converter bit XOR its invert flag. A disabled input contributes nothing, so the sample lies in -4..+4.
- R2: After reset the phase register is 0. Each clock it adds `freq_word` modulo 2^32. The lookup address is the top 8 bits of the phase register.
- R3: Each clock the sample is multiplied by the signed sine byte (bits 31:24 of the addressed entry) and by the signed cosine byte (bits 23:16) to form the sine and cosine products.
- R4: With `mode` = 0 (Sinc1) held from the previous clock, each first-stage integrator is loaded with its current product.
- R5: With `mode` = 1 (Sinc2) held from the previous clock, each first-stage integrator adds its current product to its value.
- R6: On any clock where `mode` differs from its value in the previous clock, both first-stage integrators become 0. The mode register holds Sinc1 after reset.
- R7: Each clock without a read, each second-stage integrator adds the first-stage value it held before that clock.
- R8: While `acc_rd` is high, `acc_sin` and `acc_cos` show the sums being read. At that clock edge each second stage is loaded with its first-stage value, which discards the old sum.
- R9: `dac_sin` is bits 15:8 and `dac_cos` is bits 7:0 of the addressed entry, each with its MSB inverted. The values are combinational from the phase register and the RAM.
- R10: A write (`lut_we`) stores `lut_wdata` at `lut_waddr` on the clock edge. The stored value is used from the next cycle.
- R11: Reset clears the phase register, every integrator and every RAM entry. After reset the sums read 0 and both DAC bytes read 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_bits | input | 4 | One-bit converter outputs |
| in_en | input | 4 | Per-input enable |
| in_inv | input | 4 | Per-input inversion |
| freq_word | input | 32 | Phase increment per clock |
| mode | input | 1 | 0 = Sinc1, 1 = Sinc2 |
| acc_rd | input | 1 | Read strobe; clears the second stage |
| lut_we | input | 1 | Lookup RAM write enable |
| lut_waddr | input | 8 | Lookup RAM write address |
| lut_wdata | input | 32 | Lookup RAM write data |
| acc_sin | output | 44 | Second-stage sine sum, signed |
| acc_cos | output | 44 | Second-stage cosine sum, signed |
| dac_sin | output | 8 | Offset-binary sine DAC byte |
| dac_cos | output | 8 | Offset-binary cosine DAC byte |

## Verification
A sample and its products are used at the first clock edge after the inputs are applied. The first stage holds the result after that edge. The sums show the effect one edge later, because the second stage adds the old first-stage value. The DAC bytes follow the phase register in the same cycle.

The bench drives inputs on the falling edge and advances its reference model at each rising edge. It compares all four outputs a quarter period after every rising edge, so each result is checked in the cycle it is due, including the clears on a read and on a mode change.

// File: rtl/qcor_pkg.sv
package qcor_pkg;
   typedef enum logic {
      MODE_SINC1 = 1'b0,
      MODE_SINC2 = 1'b1
   } integ_mode_e;

   typedef struct packed {
      logic [7:0] sin_ref;
      logic [7:0] cos_ref;
      logic [7:0] sin_dac;
      logic [7:0] cos_dac;
   } lut_entry_t;

   function automatic logic [7:0] to_offset(input logic [7:0] v);
      return {~v[7], v[6:0]};
   endfunction
endpackage

// File: rtl/qcor_combine.sv
module qcor_combine #(
   parameter int NUM_IN = 4,
   parameter int CNT_W  = $clog2(NUM_IN + 1),
   parameter int SAMP_W = CNT_W + 1
) (
   input  logic [NUM_IN-1:0]        bits_i,
   input  logic [NUM_IN-1:0]        en_i,
   input  logic [NUM_IN-1:0]        inv_i,
   output logic signed [SAMP_W-1:0] sample_o
);
   logic [NUM_IN-1:0] vote_up;
   logic [NUM_IN-1:0] vote_dn;
   logic [CNT_W-1:0]  n_up;
   logic [CNT_W-1:0]  n_dn;

   for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
      logic adj;
      assign adj        = bits_i[g] ^ inv_i[g];
      assign vote_up[g] = en_i[g] & adj;
      assign vote_dn[g] = en_i[g] & ~adj;
   end

   always_comb begin
      n_up = '0;
      n_dn = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         n_up = n_up + CNT_W'(vote_up[i]);
         n_dn = n_dn + CNT_W'(vote_dn[i]);
      end
   end

   assign sample_o = $signed({1'b0, n_up}) - $signed({1'b0, n_dn});
endmodule

// File: rtl/qcor_nco.sv
module qcor_nco
   import qcor_pkg::*;
#(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 8,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] freq_i,
   input  logic               we_i,
   input  logic [ADDR_W-1:0]  waddr_i,
   input  lut_entry_t         wdata_i,
   output lut_entry_t         entry_o,
   output logic [7:0]         dac_sin_o,
   output logic [7:0]         dac_cos_o
);
   logic [PHASE_W-1:0] phase_q;
   logic [ADDR_W-1:0]  raddr;
   lut_entry_t         mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + freq_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   assign raddr     = phase_q[PHASE_W-1 -: ADDR_W];
   assign entry_o   = mem[raddr];
   assign dac_sin_o = to_offset(entry_o.sin_dac);
   assign dac_cos_o = to_offset(entry_o.cos_dac);

   // R2: phase steps by the frequency word each clock
   a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_q == $past(phase_q) + $past(freq_i));
   // R9: DAC MSB is the inverse of the stored MSB
   a_r9_dac_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sin_o[7] != entry_o.sin_dac[7]) && (dac_cos_o[7] != entry_o.cos_dac[7]));
endmodule

// File: rtl/qcor_integ.sv
module qcor_integ
   import qcor_pkg::*;
#(
   parameter int PROD_W = 12,
   parameter int INT1_W = 28,
   parameter int INT2_W = 44
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  integ_mode_e              mode_i,
   input  logic                     mode_chg_i,
   input  logic                     rd_i,
   input  logic signed [PROD_W-1:0] prod_i,
   output logic signed [INT2_W-1:0] sum_o
);
   logic signed [INT1_W-1:0] int1_q;
   logic signed [INT2_W-1:0] int2_q;
   logic signed [INT1_W-1:0] prod_ext;
   logic signed [INT2_W-1:0] int1_ext;

   assign prod_ext = INT1_W'(prod_i);
   assign int1_ext = INT2_W'(int1_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int1_q <= '0;
      end else if (mode_chg_i) begin
         int1_q <= '0;
      end else if (mode_i == MODE_SINC2) begin
         int1_q <= int1_q + prod_ext;
      end else begin
         int1_q <= prod_ext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    int2_q <= '0;
      else if (rd_i) int2_q <= int1_ext;
      else           int2_q <= int2_q + int1_ext;
   end

   assign sum_o = int2_q;

   // R6: a mode change leaves the first stage at zero
   a_r6_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg_i |=> int1_q == '0);
   // R4: Sinc1 loads the product
   a_r4_sinc1_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg_i && mode_i == MODE_SINC1) |=> int1_q == $past(prod_ext));
   // R8: a read restarts the second stage from the first stage
   a_r8_read_restart: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> int2_q == INT2_W'($past(int1_q)));
   // R7: without a read the second stage accumulates
   a_r7_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> int2_q == $past(int2_q) + INT2_W'($past(int1_q)));
endmodule

// File: rtl/quad_correlator.sv
module quad_correlator
   import qcor_pkg::*;
#(
   parameter int NUM_IN     = 4,
   parameter int PHASE_W    = 32,
   parameter int ADDR_W     = 8,
   parameter int SPAN_LOG2  = 16,
   localparam int CNT_W     = $clog2(NUM_IN + 1),
   localparam int SAMP_W    = CNT_W + 1,
   localparam int PROD_W    = SAMP_W + 8,
   localparam int INT1_W    = PROD_W + SPAN_LOG2,
   localparam int INT2_W    = INT1_W + SPAN_LOG2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IN-1:0]   adc_bits,
   input  logic [NUM_IN-1:0]   in_en,
   input  logic [NUM_IN-1:0]   in_inv,
   input  logic [PHASE_W-1:0]  freq_word,
   input  logic                mode,
   input  logic                acc_rd,
   input  logic                lut_we,
   input  logic [ADDR_W-1:0]   lut_waddr,
   input  logic [31:0]         lut_wdata,
   output logic [INT2_W-1:0]   acc_sin,
   output logic [INT2_W-1:0]   acc_cos,
   output logic [7:0]          dac_sin,
   output logic [7:0]          dac_cos
);
   if (NUM_IN < 1 || NUM_IN > 4) begin : g_bad_in
      $error("quad_correlator: NUM_IN must be 1..4");
   end
   if (ADDR_W > PHASE_W || ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("quad_correlator: ADDR_W out of range");
   end
   if (SPAN_LOG2 < 1) begin : g_bad_span
      $error("quad_correlator: SPAN_LOG2 must be positive");
   end

   logic signed [SAMP_W-1:0] sample;
   lut_entry_t               entry;
   integ_mode_e              mode_cur;
   integ_mode_e              mode_q;
   logic                     mode_chg;
   logic signed [INT2_W-1:0] sums [2];

   assign mode_cur = integ_mode_e'(mode);

   qcor_combine #(.NUM_IN(NUM_IN), .CNT_W(CNT_W), .SAMP_W(SAMP_W)) u_combine (
      .bits_i  (adc_bits),
      .en_i    (in_en),
      .inv_i   (in_inv),
      .sample_o(sample)
   );

   qcor_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_nco (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq_i   (freq_word),
      .we_i     (lut_we),
      .waddr_i  (lut_waddr),
      .wdata_i  (lut_entry_t'(lut_wdata)),
      .entry_o  (entry),
      .dac_sin_o(dac_sin),
      .dac_cos_o(dac_cos)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_SINC1;
      else        mode_q <= mode_cur;
   end
   assign mode_chg = (mode_cur != mode_q);

   for (genvar c = 0; c < 2; c++) begin : g_chan
      logic signed [7:0]        ref_b;
      logic signed [PROD_W-1:0] prod;
      assign ref_b = (c == 0) ? entry.sin_ref : entry.cos_ref;
      assign prod  = PROD_W'(sample) * PROD_W'(ref_b);

      qcor_integ #(.PROD_W(PROD_W), .INT1_W(INT1_W), .INT2_W(INT2_W)) u_integ (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode_i    (mode_cur),
         .mode_chg_i(mode_chg),
         .rd_i      (acc_rd),
         .prod_i    (prod),
         .sum_o     (sums[c])
      );

      // R3: product magnitude bounded by inputs times full-scale byte
      a_r3_prod_bound: assert property (@(posedge clk) disable iff (!rst_n)
         (prod <= PROD_W'(NUM_IN * 128)) && (prod >= -PROD_W'(NUM_IN * 128)));
   end

   assign acc_sin = sums[0];
   assign acc_cos = sums[1];

   // R1: sample bounded by the enabled input count
   a_r1_sample_range: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sample) <= 32'($countones(in_en))) && (-32'(sample) <= 32'($countones(in_en))));
endmodule

// File: tb/test_quad_correlator.sv
module test_quad_correlator;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  adc_bits = '0, in_en = '0, in_inv = '0;
   logic [31:0] freq_word = '0;
   logic        mode = 1'b0, acc_rd = 1'b0, lut_we = 1'b0;
   logic [7:0]  lut_waddr = '0;
   logic [31:0] lut_wdata = '0;
   logic [43:0] acc_sin, acc_cos;
   logic [7:0]  dac_sin, dac_cos;

   int total = 0, bad = 0;
   bit finished = 0;
   string cur_req = "R11";

   // reference model state
   logic [31:0] m_mem [256];
   logic [31:0] m_ph;
   longint m_i1s, m_i1c, m_i2s, m_i2c;
   bit m_mode;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_correlator i_quad_correlator (
      .clk(clk), .rst_n(rst_n), .adc_bits(adc_bits), .in_en(in_en), .in_inv(in_inv),
      .freq_word(freq_word), .mode(mode), .acc_rd(acc_rd), .lut_we(lut_we),
      .lut_waddr(lut_waddr), .lut_wdata(lut_wdata), .acc_sin(acc_sin),
      .acc_cos(acc_cos), .dac_sin(dac_sin), .dac_cos(dac_cos)
   );

   task automatic check(string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   function automatic int model_sample();
      int s = 0;
      for (int i = 0; i < 4; i++)
         if (in_en[i]) s += ((adc_bits[i] ^ in_inv[i]) ? 1 : -1);
      return s;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_mem[i] = '0;
      m_ph = '0; m_i1s = 0; m_i1c = 0; m_i2s = 0; m_i2c = 0; m_mode = 0;
   endtask

   task automatic model_step();
      int s = model_sample();
      logic [31:0] e = m_mem[m_ph[31:24]];
      longint ps = longint'(s) * longint'($signed(e[31:24]));
      longint pc = longint'(s) * longint'($signed(e[23:16]));
      longint o1s = m_i1s, o1c = m_i1c;
      if (mode != m_mode) begin m_i1s = 0; m_i1c = 0; end
      else if (mode) begin m_i1s += ps; m_i1c += pc; end
      else begin m_i1s = ps; m_i1c = pc; end
      if (acc_rd) begin m_i2s = o1s; m_i2c = o1c; end
      else begin m_i2s += o1s; m_i2c += o1c; end
      m_mode = mode;
      m_ph = m_ph + freq_word;
      if (lut_we) m_mem[lut_waddr] = lut_wdata;
   endtask

   task automatic compare();
      logic [31:0] e = m_mem[m_ph[31:24]];
      check("acc_sin", longint'($signed(acc_sin)), m_i2s);
      check("acc_cos", longint'($signed(acc_cos)), m_i2c);
      check("dac_sin", longint'(dac_sin), longint'({~e[15], e[14:8]}));
      check("dac_cos", longint'(dac_cos), longint'({~e[7], e[6:0]}));
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      #(CLK_PERIOD/4);
      compare();
      @(negedge clk);
   endtask

   // random converter bits each cycle with fixed enable/invert
   task automatic run(int n, bit rd_every);
      for (int k = 0; k < n; k++) begin
         adc_bits = 4'($urandom);
         acc_rd = rd_every ? ((k % 17) == 16) : 1'b0;
         tick();
      end
      acc_rd = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R11: reset state at the ports
      cur_req = "R11";
      check("acc_sin_rst", longint'($signed(acc_sin)), 0);
      check("acc_cos_rst", longint'($signed(acc_cos)), 0);
      check("dac_sin_rst", longint'(dac_sin), 128);
      check("dac_cos_rst", longint'(dac_cos), 128);
      rst_n = 1'b1;

      // R10 and R9: load the table; DAC bytes checked against model
      cur_req = "R10";
      freq_word = 32'h0100_0000;
      for (int a = 0; a < 256; a++) begin
         lut_we = 1'b1; lut_waddr = 8'(a); lut_wdata = $urandom;
         tick();
      end
      lut_we = 1'b0;
      cur_req = "R9";
      run(300, 0);

      // R1 and R3: all enabled, no inversion, Sinc1 (R4)
      cur_req = "R4";
      in_en = 4'hF; in_inv = 4'h0; mode = 1'b0; freq_word = 32'h0123_4567;
      run(200, 1);
      // R1: inverted and partially enabled lanes
      cur_req = "R1";
      in_en = 4'b1011; in_inv = 4'b0110; run(200, 1);
      in_en = 4'b0000; run(60, 1);
      in_en = 4'b1111; in_inv = 4'b1111; run(100, 1);
      cur_req = "R3";
      for (int k = 0; k < 40; k++) begin
         adc_bits = 4'hF; in_inv = 4'h0; in_en = 4'hF; tick();
      end

      // R5 and R7: Sinc2 accumulation, with R6 clear at the switch
      cur_req = "R6";
      mode = 1'b1; tick();
      cur_req = "R5";
      freq_word = 32'h0777_0001; run(300, 1);
      cur_req = "R7";
      run(150, 0);
      // R8: read strobe clears and restarts
      cur_req = "R8";
      acc_rd = 1'b1; tick(); acc_rd = 1'b1; tick(); acc_rd = 1'b0; tick();

      // R6: back-to-back switches Sinc2 -> Sinc1 -> Sinc2
      cur_req = "R6";
      mode = 1'b0; tick(); mode = 1'b1; tick();
      run(100, 1);
      for (int k = 0; k < 50; k++) begin
         mode = 1'(k % 3 == 0); adc_bits = 4'($urandom); acc_rd = 1'(k % 7 == 0); tick();
      end
      acc_rd = 1'b0;

      // R2: phase wrap with large frequency word, and zero frequency
      cur_req = "R2";
      freq_word = 32'hFFFF_FFF3; run(200, 1);
      freq_word = 32'h0; run(50, 1);

      // random mix including table rewrites during correlation
      cur_req = "R10";
      for (int k = 0; k < 1000; k++) begin
         in_en = 4'($urandom); in_inv = 4'($urandom); adc_bits = 4'($urandom);
         mode = 1'($urandom % 8 == 0) ^ mode; acc_rd = 1'($urandom % 20 == 0);
         lut_we = 1'($urandom % 5 == 0); lut_waddr = 8'($urandom); lut_wdata = $urandom;
         freq_word = ($urandom % 50 == 0) ? $urandom : freq_word;
         tick();
      end
      lut_we = 1'b0; acc_rd = 1'b0;

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule